// File: doc/BRIEF.md
# Bit-Masked Multi-Aspect Block RAM

A 4096-bit synchronous memory with one write port and one read port, each with its own clock, clock enable and access enable. A parameter sets the aspect ratio: 256 words of 16 bits, 512 of 8, 1024 of 4 or 2048 of 2. Storage is always a physical array of 256 rows of 16 bits. A narrow mode stores each logical word in one lane of a row, and the upper address bits choose that lane.

The widest mode accepts a per-bit write mask in which a 1 protects the stored bit. A parameter can move each port to the falling edge of its clock. A preload image parameter sets the array contents at start-up, except for the bits of logical address 0, which always start at zero. If the write port is never enabled, the block acts as a ROM that holds the image.

The data and address ports always have their full width (16 and 11 bits). In a narrow mode the block uses only the low data bits and low address bits that the mode needs.

Top module: `bram4k_masked`

## Requirements
- R1: The data width is 16, 8, 4 or 2 bits for aspect codes 0, 1, 2 and 3, and the address width is 8 plus the code. In every mode, `rd_data` bits at or above the data width read 0.
- R2: Logical address a maps to physical row a[7:0] and lane a[AW-1:8]. Lane k holds bits [k*DW +: DW] of the row.
- R3: The word at `wr_addr` takes `wr_data` on an active write-clock edge only when `wr_en` and `wr_clk_en` are both 1. At any other edge the memory is unchanged.
- R4: In the 16-bit mode, a `wr_mask` bit of 1 keeps that stored bit, and a 0 lets the matching `wr_data` bit be written.
- R5: In the narrow modes `wr_mask` has no effect. All DW bits of the addressed word are written.
- R6: `rd_data` shows the word at `rd_addr` one active read-clock edge after that edge, when `rd_en` and `rd_clk_en` are both 1. Otherwise it holds its value.
- R7: When a write and a read hit the same address on the same edge of a shared clock, the read returns the old contents.
- R8: Parameters `WR_FALLING` and `RD_FALLING` move the write or read port to the falling edge of its clock. A falling-edge write that precedes a rising-edge read in the same clock period is seen by that read.
- R9: Physical row r starts as `INIT[16*r +: 16]`, except that the DW bits of logical address 0 start at 0. With no writes, reads return this image.
- R10: `rst` high on an active read-clock edge clears `rd_data` to 0 at that edge. Reset does not change the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset of the read output register |
| wr_clk | input | 1 | Write port clock |
| wr_clk_en | input | 1 | Write clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 11 | Write address (low AW bits used) |
| wr_data | input | 16 | Write data (low DW bits used) |
| wr_mask | input | 16 | Per-bit write protect, 16-bit mode only |
| rd_clk | input | 1 | Read port clock |
| rd_clk_en | input | 1 | Read clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 11 | Read address (low AW bits used) |
| rd_data | output | 16 | Registered read data |

## Verification
The bench builds two copies of the block.

- The first uses the 256x16 aspect with both ports on the rising edge. This copy reaches the write mask, same-edge read/write collisions, the hold cases of the read enables and the preload of full rows.
- The second uses the 1024x4 aspect with the write port on the falling edge. This copy reaches lane selection by the upper address bits, the zeroed upper read bits and a mask that has no effect. It also shows that a write landing half a period before a read is visible to that read.

Both copies share one non-trivial preload image, so the exclusion of address 0 can be checked in each lane layout.

// File: rtl/bram_pkg.sv
package bram_pkg;

    localparam int PHYS_ROWS = 256;
    localparam int PHYS_W    = 16;
    localparam int ROW_AW    = 8;
    localparam int MAX_AW    = 11;
    localparam int SLICE_W   = 3;

    typedef enum logic [1:0] {
        ASPECT_256X16  = 2'd0,
        ASPECT_512X8   = 2'd1,
        ASPECT_1024X4  = 2'd2,
        ASPECT_2048X2  = 2'd3
    } aspect_e;

    // one write operation after lane decode
    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [PHYS_W-1:0] bit_en;
        logic [PHYS_W-1:0] data;
    } wr_req_t;

    // one read selection: physical row and lane
    typedef struct packed {
        logic [ROW_AW-1:0]  row;
        logic [SLICE_W-1:0] slice;
    } rd_sel_t;

    function automatic int lane_w(aspect_e a);
        return PHYS_W >> int'(a);
    endfunction

    function automatic int addr_w(aspect_e a);
        return ROW_AW + int'(a);
    endfunction

endpackage

// File: rtl/bram_wr_decode.sv
module bram_wr_decode
    import bram_pkg::*;
#(
    parameter aspect_e ASPECT = ASPECT_256X16
) (
    input  logic                 en,
    input  logic [MAX_AW-1:0]    addr,
    input  logic [PHYS_W-1:0]    data,
    input  logic [PHYS_W-1:0]    mask,
    output wr_req_t              req
);
    localparam int DW  = lane_w(ASPECT);
    localparam int AW  = addr_w(ASPECT);
    localparam int REP = PHYS_W / DW;
    localparam logic [PHYS_W-1:0] LANE_ONES = PHYS_W'((1 << DW) - 1);

    generate
        if (DW == PHYS_W) begin : g_wide
            logic unused_addr;
            assign unused_addr = ^addr[MAX_AW-1:ROW_AW];
            always_comb begin
                req.row    = addr[ROW_AW-1:0];
                req.data   = data;
                req.bit_en = en ? ~mask : '0;
            end
        end else begin : g_narrow
            logic unused_in;
            assign unused_in = ^{mask, data[PHYS_W-1:DW]};
            if (AW < MAX_AW) begin : g_hi
                logic unused_hi;
                assign unused_hi = ^addr[MAX_AW-1:AW];
            end
            always_comb begin
                int unsigned sl;
                sl         = int'(addr[AW-1:ROW_AW]);
                req.row    = addr[ROW_AW-1:0];
                req.data   = {REP{data[DW-1:0]}};
                req.bit_en = en ? (LANE_ONES << (sl * DW)) : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/bram_store.sv
module bram_store
    import bram_pkg::*;
#(
    parameter aspect_e                   ASPECT = ASPECT_256X16,
    parameter logic [PHYS_ROWS*PHYS_W-1:0] INIT = '0
) (
    input  logic              wr_clk_e,
    input  logic              rd_clk_e,
    input  logic              rst,
    input  wr_req_t           wreq,
    input  logic              rd_go,
    input  rd_sel_t           rsel,
    output logic [PHYS_W-1:0] word_q,
    output logic [SLICE_W-1:0] slice_q
);
    localparam int DW = lane_w(ASPECT);

    logic [PHYS_W-1:0] mem [PHYS_ROWS];

    initial begin
        for (int r = 0; r < PHYS_ROWS; r++) begin
            mem[r] = INIT[r*PHYS_W +: PHYS_W];
        end
        mem[0][DW-1:0] = '0;
    end

    always_ff @(posedge wr_clk_e) begin
        for (int b = 0; b < PHYS_W; b++) begin
            if (wreq.bit_en[b]) begin
                mem[wreq.row][b] <= wreq.data[b];
            end
        end
    end

    always_ff @(posedge rd_clk_e) begin
        if (rst) begin
            word_q  <= '0;
            slice_q <= '0;
        end else if (rd_go) begin
            word_q  <= mem[rsel.row];
            slice_q <= rsel.slice;
        end
    end

endmodule

// File: rtl/bram_rd_slice.sv
module bram_rd_slice
    import bram_pkg::*;
#(
    parameter aspect_e ASPECT = ASPECT_256X16
) (
    input  logic [PHYS_W-1:0]  word,
    input  logic [SLICE_W-1:0] slice,
    output logic [PHYS_W-1:0]  rdata
);
    localparam int DW = lane_w(ASPECT);
    localparam logic [PHYS_W-1:0] LANE_ONES = PHYS_W'((1 << DW) - 1);

    generate
        if (DW == PHYS_W) begin : g_wide
            logic unused_slice;
            assign unused_slice = ^slice;
            assign rdata = word;
        end else begin : g_narrow
            always_comb begin
                rdata = (word >> (int'(slice) * DW)) & LANE_ONES;
            end
        end
    endgenerate

endmodule

// File: rtl/bram4k_masked.sv
module bram4k_masked
    import bram_pkg::*;
#(
    parameter aspect_e                     ASPECT     = ASPECT_256X16,
    parameter bit                          WR_FALLING = 1'b0,
    parameter bit                          RD_FALLING = 1'b0,
    parameter logic [PHYS_ROWS*PHYS_W-1:0] INIT       = '0
) (
    input  logic        rst,
    input  logic        wr_clk,
    input  logic        wr_clk_en,
    input  logic        wr_en,
    input  logic [10:0] wr_addr,
    input  logic [15:0] wr_data,
    input  logic [15:0] wr_mask,
    input  logic        rd_clk,
    input  logic        rd_clk_en,
    input  logic        rd_en,
    input  logic [10:0] rd_addr,
    output logic [15:0] rd_data
);
    localparam int DW = lane_w(ASPECT);
    localparam int AW = addr_w(ASPECT);

    logic              wr_clk_eff;
    logic              rd_clk_eff;
    wr_req_t           wreq;
    rd_sel_t           rsel;
    logic [PHYS_W-1:0] word_q;
    logic [SLICE_W-1:0] slice_q;
    logic [PHYS_W-1:0] wr_bit_en;

    generate
        if (WR_FALLING) begin : g_wneg
            assign wr_clk_eff = ~wr_clk;
        end else begin : g_wpos
            assign wr_clk_eff = wr_clk;
        end
        if (RD_FALLING) begin : g_rneg
            assign rd_clk_eff = ~rd_clk;
        end else begin : g_rpos
            assign rd_clk_eff = rd_clk;
        end

        if (DW == PHYS_W) begin : g_rsel_wide
            logic unused_raddr;
            assign unused_raddr = ^rd_addr[MAX_AW-1:ROW_AW];
            assign rsel.slice = '0;
        end else begin : g_rsel_narrow
            if (AW < MAX_AW) begin : g_hi
                logic unused_raddr;
                assign unused_raddr = ^rd_addr[MAX_AW-1:AW];
            end
            assign rsel.slice = SLICE_W'(rd_addr[AW-1:ROW_AW]);
        end
    endgenerate

    assign rsel.row  = rd_addr[ROW_AW-1:0];
    assign wr_bit_en = wreq.bit_en;

    bram_wr_decode #(.ASPECT(ASPECT)) u_wdec (
        .en   (wr_en & wr_clk_en),
        .addr (wr_addr),
        .data (wr_data),
        .mask (wr_mask),
        .req  (wreq)
    );

    bram_store #(.ASPECT(ASPECT), .INIT(INIT)) u_store (
        .wr_clk_e (wr_clk_eff),
        .rd_clk_e (rd_clk_eff),
        .rst      (rst),
        .wreq     (wreq),
        .rd_go    (rd_en & rd_clk_en),
        .rsel     (rsel),
        .word_q   (word_q),
        .slice_q  (slice_q)
    );

    bram_rd_slice #(.ASPECT(ASPECT)) u_rslice (
        .word  (word_q),
        .slice (slice_q),
        .rdata (rd_data)
    );

endmodule

// File: rtl/bram4k_masked_chk.sv
module bram4k_masked_chk
    import bram_pkg::*;
#(
    parameter aspect_e ASPECT = ASPECT_256X16
) (
    input logic        rst,
    input logic        wr_clk_eff,
    input logic        rd_clk_eff,
    input logic        wr_en,
    input logic        wr_clk_en,
    input logic [15:0] wr_mask,
    input logic [15:0] wr_bit_en,
    input logic        rd_en,
    input logic        rd_clk_en,
    input logic [15:0] rd_data
);
    localparam int DW = lane_w(ASPECT);

    // R3
    wr_idle_no_bits_chk: assert property (@(posedge wr_clk_eff) disable iff (rst)
        !(wr_en && wr_clk_en) |-> (wr_bit_en == 16'h0));

    // R6
    rd_hold_chk: assert property (@(posedge rd_clk_eff) disable iff (rst)
        !(rd_en && rd_clk_en) |=> $stable(rd_data));

    // R10
    rd_reset_clear_chk: assert property (@(posedge rd_clk_eff)
        rst |=> (rd_data == 16'h0));

    generate
        if (DW == PHYS_W) begin : g_wide
            // R4
            wr_mask_blocks_chk: assert property (@(posedge wr_clk_eff) disable iff (rst)
                (wr_en && wr_clk_en) |-> ((wr_bit_en & wr_mask) == 16'h0));
        end else begin : g_narrow
            // R5
            wr_mask_ignored_chk: assert property (@(posedge wr_clk_eff) disable iff (rst)
                (wr_en && wr_clk_en) |-> ($countones(wr_bit_en) == DW));
            // R1
            rd_upper_zero_chk: assert property (@(posedge rd_clk_eff) disable iff (rst)
                ((rd_data >> DW) == 16'h0));
        end
    endgenerate

endmodule

bind bram4k_masked bram4k_masked_chk #(.ASPECT(ASPECT)) u_chk (
    .rst        (rst),
    .wr_clk_eff (wr_clk_eff),
    .rd_clk_eff (rd_clk_eff),
    .wr_en      (wr_en),
    .wr_clk_en  (wr_clk_en),
    .wr_mask    (wr_mask),
    .wr_bit_en  (wr_bit_en),
    .rd_en      (rd_en),
    .rd_clk_en  (rd_clk_en),
    .rd_data    (rd_data)
);

// File: tb/test_bram4k_masked.sv
module test_bram4k_masked;
    import bram_pkg::*;

    function automatic logic [4095:0] make_img();
        logic [4095:0] v;
        for (int r = 0; r < 256; r++) begin
            v[r*16 +: 16] = 16'(r * 291) ^ 16'hA5C3;
        end
        return v;
    endfunction

    localparam logic [4095:0] IMG = make_img();

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // instance A: 256x16, both ports rising
    logic        a_wce = 0, a_we = 0, a_rce = 0, a_re = 0;
    logic [10:0] a_wa = 0, a_ra = 0;
    logic [15:0] a_wd = 0, a_wm = 0, a_rd;
    // instance B: 1024x4, write on falling edge, read rising
    logic        b_wce = 0, b_we = 0, b_rce = 0, b_re = 0;
    logic [10:0] b_wa = 0, b_ra = 0;
    logic [15:0] b_wd = 0, b_wm = 0, b_rd;

    bram4k_masked #(.ASPECT(ASPECT_256X16), .INIT(IMG)) i_bram4k_masked (
        .rst(rst), .wr_clk(clk), .wr_clk_en(a_wce), .wr_en(a_we), .wr_addr(a_wa),
        .wr_data(a_wd), .wr_mask(a_wm), .rd_clk(clk), .rd_clk_en(a_rce),
        .rd_en(a_re), .rd_addr(a_ra), .rd_data(a_rd));

    bram4k_masked #(.ASPECT(ASPECT_1024X4), .WR_FALLING(1'b1), .INIT(IMG)) i_bram4k_masked_nar (
        .rst(rst), .wr_clk(clk), .wr_clk_en(b_wce), .wr_en(b_we), .wr_addr(b_wa),
        .wr_data(b_wd), .wr_mask(b_wm), .rd_clk(clk), .rd_clk_en(b_rce),
        .rd_en(b_re), .rd_addr(b_ra), .rd_data(b_rd));

    typedef struct {
        int unsigned due;
        bit          inst;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          fails = 0;
    int unsigned cyc = 0;
    logic [15:0] model_a [256];
    logic [3:0]  model_b [1024];
    logic [15:0] last_a = 0, last_b = 0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int r = 0; r < 256; r++) model_a[r] = IMG[r*16 +: 16];
        model_a[0] = 16'h0;
        // R2: lane k of row r holds address r + 256*k
        for (int a = 0; a < 1024; a++) model_b[a] = IMG[(a % 256)*16 + (a / 256)*4 +: 4];
        model_b[0] = 4'h0;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops items whose result is due at this falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, it.inst ? b_rd : a_rd, it.exp);
        end
    end

    // one cycle on port A: optional write and optional read
    task automatic op_a(input bit w, input logic [7:0] wa, input logic [15:0] wd,
                        input logic [15:0] wm, input bit wce,
                        input bit r, input logic [7:0] ra, input bit rce, input string req);
        item_t it;
        a_we = w; a_wce = wce; a_wa = {3'b0, wa}; a_wd = wd; a_wm = wm;
        a_re = r; a_rce = rce; a_ra = {3'b0, ra};
        if (r) begin
            if (rce) last_a = model_a[ra];
            it.due = cyc + 1; it.inst = 1'b0; it.exp = last_a; it.req = req;
            sb.push_back(it);
        end
        if (w && wce) model_a[wa] = (model_a[wa] & wm) | (wd & ~wm);
        @(posedge clk); #1;
        a_we = 0; a_re = 0; a_wce = 0; a_rce = 0;
    endtask

    // one cycle on port B: write lands at the falling edge before the read edge
    task automatic op_b(input bit w, input logic [9:0] wa, input logic [3:0] wd,
                        input logic [15:0] wm, input bit r, input logic [9:0] ra,
                        input string req);
        item_t it;
        b_we = w; b_wce = 1; b_wa = {1'b0, wa}; b_wd = {12'hFFF, wd}; b_wm = wm;
        b_re = r; b_rce = 1; b_ra = {1'b0, ra};
        if (w) model_b[wa] = wd;
        if (r) begin
            last_b = {12'h0, model_b[ra]};
            it.due = cyc + 1; it.inst = 1'b1; it.exp = last_b; it.req = req;
            sb.push_back(it);
        end
        @(posedge clk); #1;
        b_we = 0; b_re = 0; b_wce = 0; b_rce = 0;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: output register cleared by reset
        check("R10 A reset", a_rd, 16'h0);
        check("R10 B reset", b_rd, 16'h0);
        rst = 0;

        // R9: preload image, address 0 excluded, read-only use
        op_a(0, 0, 0, 0, 0, 1, 8'd1,   1, "R9 A preload 1");
        op_a(0, 0, 0, 0, 0, 1, 8'd0,   1, "R9 A address 0 zero");
        op_a(0, 0, 0, 0, 0, 1, 8'd255, 1, "R9 A preload 255");
        op_b(0, 0, 0, 0, 1, 10'h000, "R9 B address 0 zero");
        op_b(0, 0, 0, 0, 1, 10'h100, "R9 B lane 1 of row 0 kept");
        // R2 / R1: lane selection by upper address, upper read bits zero
        op_b(0, 0, 0, 0, 1, 10'h105, "R2 B row 5 lane 1");
        op_b(0, 0, 0, 0, 1, 10'h3FF, "R1 B row 255 lane 3");

        // R3: full write then read back
        op_a(1, 8'd10, 16'h1234, 16'h0000, 1, 0, 0, 0, "");
        op_a(0, 0, 0, 0, 0, 1, 8'd10, 1, "R3 A write readback");
        // R4: high byte protected
        op_a(1, 8'd10, 16'hABCD, 16'hFF00, 1, 0, 0, 0, "");
        op_a(0, 0, 0, 0, 0, 1, 8'd10, 1, "R4 A masked write");
        // R3: clock enable low blocks write
        op_a(1, 8'd10, 16'h0000, 16'h0000, 0, 0, 0, 0, "");
        op_a(0, 0, 0, 0, 0, 1, 8'd10, 1, "R3 A write clock enable low");

        // R6: hold with read clock enable low, and with read enable low
        op_a(0, 0, 0, 0, 0, 1, 8'd1, 0, "R6 A read clock enable low holds");
        op_a(0, 0, 0, 0, 0, 1, 8'd1, 1, "R6 A read updates");
        a_ra = 11'd255; a_rce = 1; a_re = 0;
        @(posedge clk); #1;
        a_rce = 0;
        check("R6 A read enable low holds", a_rd, last_a);

        // R7: same-address collision returns old data, new data next
        op_a(1, 8'd20, 16'hBEEF, 16'h0000, 1, 1, 8'd20, 1, "R7 A collision old");
        op_a(0, 0, 0, 0, 0, 1, 8'd20, 1, "R7 A after collision new");

        // R8 / R5: falling-edge write visible to read in same period; mask ignored
        op_b(1, 10'h2A7, 4'h9, 16'hFFFF, 1, 10'h2A7, "R8 B falling write seen");
        op_b(0, 0, 0, 0, 1, 10'h1A7, "R2 B neighbour lane unchanged");
        op_b(1, 10'h0A7, 4'h6, 16'hFFFF, 0, 0, "");
        op_b(0, 0, 0, 0, 1, 10'h0A7, "R5 B mask ignored");

        // R10: reset mid-run clears output, contents kept
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        check("R10 A reset again", a_rd, 16'h0);
        last_a = 16'h0;
        op_a(0, 0, 0, 0, 0, 1, 8'd20, 1, "R10 A contents survive reset");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule